// File: doc/BRIEF.md
# NaN classifier and quieting unit

This block examines one packed floating-point word per transfer and tells whether it holds a NaN, and if so whether that NaN is quiet or signaling. Four formats are supported: half, bfloat16, single and double. A format-select field picks one of them, and the word is read right-aligned in a 64-bit bus. For the same word the block also returns a quieted copy and the default NaN pattern of the selected format. Two configuration bits set how NaNs are read. One flips the meaning of the most significant fraction bit. The other removes signaling NaNs from the number system altogether.

Words enter and results leave over valid/ready streams. With the output register enabled (the default), a result appears one clock after its word is accepted. A result held at the output, valid with ready low, stays frozen. While it is held, the input side deasserts ready, so the upstream source must keep its word and configuration steady until ready returns. With the register disabled the block is purely combinational and ready passes straight through from output to input. Downstream logic uses the quieted copy to propagate a NaN operand, and the default pattern when a NaN has to be generated.

Top module: `nan_sieve`

## Requirements
- R1: Formats are encoded in `in_fmt` as 0 = half (exponent [14:10], fraction [9:0], sign [15]), 1 = bfloat16 (exponent [14:7], fraction [6:0], sign [15]), 2 = single (exponent [30:23], fraction [22:0], sign [31]) and 3 = double (exponent [62:52], fraction [51:0], sign [63]). Input bits above the selected format are ignored. With `snan_pol` = 0 and `no_snan` = 0, a word is a quiet NaN when its exponent is all ones and its fraction MSB is 1. It is a signaling NaN when its exponent is all ones, its fraction MSB is 0 and its remaining fraction bits are nonzero.
- R2: With `snan_pol` = 1 and `no_snan` = 0 the roles swap. Quiet then requires exponent all ones, fraction MSB 0 and the remaining fraction nonzero. Signaling requires exponent all ones and fraction MSB 1.
- R3: With `no_snan` = 1, every NaN is reported quiet and `out_is_sig` is always 0, whatever the value of `snan_pol`.
- R4: `out_is_nan` is 1 exactly when the exponent is all ones and the fraction is nonzero, so an infinity reports 0 under either polarity. `out_is_quiet` and `out_is_sig` are never both 1, and their OR equals `out_is_nan`.
- R5: For a signaling NaN, `out_quiet_word` is the input with the fraction MSB set (polarity 0), or with the MSB cleared and the next lower fraction bit set (polarity 1). Any other word is returned unchanged. In both outputs, every bit above the format width is 0.
- R6: With `dflt_style` 0 or 3, the default NaN has sign 0 and exponent all ones. Its fraction has only the MSB set under polarity 0, and every bit except the MSB set under polarity 1.
- R7: With `dflt_style` 1, the default NaN has sign 0, exponent all ones and an all-ones fraction. With `dflt_style` 2, it has sign 1, exponent all ones and a fraction with only the MSB set. Both patterns ignore the polarity.
- R8: With the output register enabled, a word accepted at a clock edge has its result presented with `out_valid` = 1 right after that edge. A synchronous reset clears `out_valid` and every output field to 0.
- R9: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is 1 and `out_ready` is 0, the output fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take the offered word |
| in_fmt | input | 2 | Format select (encoding in R1) |
| in_word | input | 64 | Packed word, right-aligned |
| snan_pol | input | 1 | Fraction MSB value that marks a signaling NaN |
| no_snan | input | 1 | Treat every NaN as quiet |
| dflt_style | input | 2 | Default NaN pattern choice |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Downstream takes the result |
| out_is_nan | output | 1 | Word is a NaN |
| out_is_quiet | output | 1 | Word is a quiet NaN |
| out_is_sig | output | 1 | Word is a signaling NaN |
| out_quiet_word | output | 64 | Quieted copy of the word |
| out_dflt_word | output | 64 | Default NaN for the format |

## Verification
The hardest case to reach is a polarity-1 signaling NaN whose fraction has only the MSB set. Quieting must then turn it into a quiet NaN that has only the next lower bit set. The stimulus reaches this by sweeping every half and bfloat16 word with an all-ones exponent under all four configuration combinations. A second case is a result held under back-pressure while a different word waits at the input. The stimulus drops `out_ready` just after one word is accepted, then offers a second word and watches that the first result stays frozen until the stall is released.

// File: rtl/nan_sieve_pkg.sv
package nan_sieve_pkg;

  localparam int WORD_W  = 64;
  localparam int NUM_FMT = 4;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_BF16   = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_DOUBLE = 2'd3
  } fmt_e;

  typedef struct packed {
    logic              is_nan;
    logic              is_quiet;
    logic              is_sig;
    logic [WORD_W-1:0] quiet_word;
    logic [WORD_W-1:0] dflt_word;
  } nan_res_t;

  function automatic int fmt_exp_w(input int idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      2:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmt_frac_w(input int idx);
    case (idx)
      0:       return 10;
      1:       return 7;
      2:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/nan_fmt_lane.sv
module nan_fmt_lane
  import nan_sieve_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  input  logic                  pol_i,
  input  logic                  no_snan_i,
  input  logic [1:0]            style_i,
  output nan_res_t              res_o
);
  localparam int FMT_W = 1 + EXP_W + FRAC_W;

  logic              sign_b;
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              top_bit;
  logic              low_nz;
  logic              sig_b;
  logic              quiet_b;
  logic [FRAC_W-1:0] qfrac;
  logic [FRAC_W-1:0] dfrac;
  logic              dsign;
  logic [FRAC_W-1:0] top_mask;
  logic [FRAC_W-1:0] next_mask;

  assign sign_b    = word_i[FMT_W-1];
  assign exp_f     = word_i[FRAC_W +: EXP_W];
  assign frac_f    = word_i[FRAC_W-1:0];
  assign exp_ones  = &exp_f;
  assign top_bit   = frac_f[FRAC_W-1];
  assign low_nz    = |frac_f[FRAC_W-2:0];
  assign top_mask  = {1'b1, {(FRAC_W-1){1'b0}}};
  assign next_mask = {2'b01, {(FRAC_W-2){1'b0}}};

  always_comb begin
    if (no_snan_i) begin
      quiet_b = exp_ones & (top_bit | low_nz);
      sig_b   = 1'b0;
    end else if (!pol_i) begin
      quiet_b = exp_ones & top_bit;
      sig_b   = exp_ones & ~top_bit & low_nz;
    end else begin
      quiet_b = exp_ones & ~top_bit & low_nz;
      sig_b   = exp_ones & top_bit;
    end
  end

  always_comb begin
    qfrac = frac_f;
    if (sig_b) begin
      if (pol_i) qfrac = (frac_f & ~top_mask) | next_mask;
      else       qfrac = frac_f | top_mask;
    end
  end

  always_comb begin
    case (style_i)
      2'd1: begin
        dsign = 1'b0;
        dfrac = '1;
      end
      2'd2: begin
        dsign = 1'b1;
        dfrac = top_mask;
      end
      default: begin
        dsign = 1'b0;
        dfrac = pol_i ? ~top_mask : top_mask;
      end
    endcase
  end

  always_comb begin
    res_o                        = '0;
    res_o.is_nan                 = exp_ones & (|frac_f);
    res_o.is_quiet               = quiet_b;
    res_o.is_sig                 = sig_b;
    res_o.quiet_word[FMT_W-1:0]  = {sign_b, exp_f, qfrac};
    res_o.dflt_word[FMT_W-1:0]   = {dsign, {EXP_W{1'b1}}, dfrac};
  end

endmodule

// File: rtl/nan_fmt_sel.sv
module nan_fmt_sel
  import nan_sieve_pkg::*;
(
  input  nan_res_t   lane_i [NUM_FMT],
  input  logic [1:0] fmt_i,
  output nan_res_t   res_o
);
  always_comb begin
    res_o = '0;
    for (int k = 0; k < NUM_FMT; k++) begin
      if (fmt_i == k[1:0]) res_o = lane_i[k];
    end
  end
endmodule

// File: rtl/nan_out_stage.sv
module nan_out_stage
  import nan_sieve_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  output logic     in_ready,
  input  nan_res_t res_i,
  output logic     out_valid,
  input  logic     out_ready,
  output nan_res_t res_o
);
  generate
    if (REG_OUT) begin : g_reg
      logic     vld_q;
      nan_res_t res_q;
      assign in_ready  = ~vld_q | out_ready;
      assign out_valid = vld_q;
      assign res_o     = res_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= 1'b0;
          res_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) res_q <= res_i;
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst;
      assign in_ready   = out_ready;
      assign out_valid  = in_valid;
      assign res_o      = res_i;
    end
  endgenerate
endmodule

// File: rtl/nan_sieve.sv
module nan_sieve
  import nan_sieve_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_fmt,
  input  logic [WORD_W-1:0] in_word,
  input  logic              snan_pol,
  input  logic              no_snan,
  input  logic [1:0]        dflt_style,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_nan,
  output logic              out_is_quiet,
  output logic              out_is_sig,
  output logic [WORD_W-1:0] out_quiet_word,
  output logic [WORD_W-1:0] out_dflt_word
);
  nan_res_t lanes [NUM_FMT];
  nan_res_t picked;
  nan_res_t held;

  generate
    for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
      localparam int EW = fmt_exp_w(g);
      localparam int FW = fmt_frac_w(g);
      nan_fmt_lane #(.EXP_W(EW), .FRAC_W(FW)) u_lane (
        .word_i    (in_word[EW+FW:0]),
        .pol_i     (snan_pol),
        .no_snan_i (no_snan),
        .style_i   (dflt_style),
        .res_o     (lanes[g])
      );
    end
  endgenerate

  nan_fmt_sel u_sel (
    .lane_i (lanes),
    .fmt_i  (in_fmt),
    .res_o  (picked)
  );

  nan_out_stage #(.REG_OUT(REG_OUT)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .res_i     (picked),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .res_o     (held)
  );

  assign out_is_nan     = held.is_nan;
  assign out_is_quiet   = held.is_quiet;
  assign out_is_sig     = held.is_sig;
  assign out_quiet_word = held.quiet_word;
  assign out_dflt_word  = held.dflt_word;
endmodule

// File: rtl/nan_sieve_chk.sv
module nan_sieve_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_fmt,
  input logic [30:0] in_lo,
  input logic        no_snan,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_is_nan,
  input logic        out_is_quiet,
  input logic        out_is_sig,
  input logic [63:0] out_quiet_word
);
  AST_CLASS_PARTITION: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!(out_is_quiet && out_is_sig) && ((out_is_quiet || out_is_sig) == out_is_nan))); // R4

  generate
    if (REG_OUT) begin : g_seq
      AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid); // R8
      AST_NOSIG_MODE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && no_snan) |=> !out_is_sig); // R3
      AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_quiet_word) && $stable(out_is_nan))); // R9
      AST_SINGLE_INF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_fmt == 2'd2 && in_lo == 31'h7F80_0000) |=> !out_is_nan); // R4
    end
  endgenerate
endmodule

bind nan_sieve nan_sieve_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_fmt         (in_fmt),
  .in_lo          (in_word[30:0]),
  .no_snan        (no_snan),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_is_nan     (out_is_nan),
  .out_is_quiet   (out_is_quiet),
  .out_is_sig     (out_is_sig),
  .out_quiet_word (out_quiet_word)
);

// File: tb/nan_sieve_tb_top.sv
module nan_sieve_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_fmt = 2'd0;
  logic [63:0] in_word = '0;
  logic        snan_pol = 1'b0;
  logic        no_snan = 1'b0;
  logic [1:0]  dflt_style = 2'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_is_nan;
  logic        out_is_quiet;
  logic        out_is_sig;
  logic [63:0] out_quiet_word;
  logic [63:0] out_dflt_word;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nan_sieve dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_word(in_word), .snan_pol(snan_pol), .no_snan(no_snan),
    .dflt_style(dflt_style), .out_valid(out_valid), .out_ready(out_ready),
    .out_is_nan(out_is_nan), .out_is_quiet(out_is_quiet), .out_is_sig(out_is_sig),
    .out_quiet_word(out_quiet_word), .out_dflt_word(out_dflt_word)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h (fmt=%0d word=%h pol=%0d ns=%0d style=%0d)",
               tag, act, exp, in_fmt, in_word, snan_pol, no_snan, dflt_style);
    end
  endtask

  function automatic void model(input int fmt, input logic [63:0] w, input bit pol,
                                input bit ns, input logic [1:0] st,
                                output bit en, output bit eq, output bit es,
                                output logic [63:0] eqw, output logic [63:0] edw);
    int ew, fw;
    logic [63:0] fm, em, e, f, rest, qf, df, sg, ds;
    bit msb, ones;
    case (fmt)
      0: begin ew = 5;  fw = 10; end
      1: begin ew = 8;  fw = 7;  end
      2: begin ew = 8;  fw = 23; end
      default: begin ew = 11; fw = 52; end
    endcase
    fm   = (64'd1 << fw) - 64'd1;
    em   = (64'd1 << ew) - 64'd1;
    e    = (w >> fw) & em;
    f    = w & fm;
    msb  = ((f >> (fw-1)) & 64'd1) != 0;
    rest = f & ((64'd1 << (fw-1)) - 64'd1);
    sg   = (w >> (ew+fw)) & 64'd1;
    ones = (e == em);
    en   = ones && (f != 0);
    if (ns) begin
      eq = en; es = 1'b0;
    end else if (!pol) begin
      eq = ones && msb; es = ones && !msb && (rest != 0);
    end else begin
      eq = ones && !msb && (rest != 0); es = ones && msb;
    end
    qf = f;
    if (es) begin
      if (pol) qf = (f & ~(64'd1 << (fw-1))) | (64'd1 << (fw-2));
      else     qf = f | (64'd1 << (fw-1));
    end
    eqw = (sg << (ew+fw)) | (e << fw) | qf;
    case (st)
      2'd1: begin ds = 0; df = fm; end
      2'd2: begin ds = 1; df = 64'd1 << (fw-1); end
      default: begin ds = 0; df = pol ? (fm >> 1) : (64'd1 << (fw-1)); end
    endcase
    edw = (ds << (ew+fw)) | (em << fw) | df;
  endfunction

  task automatic apply(input int fmt, input logic [63:0] w, input bit pol,
                       input bit ns, input logic [1:0] st);
    bit en, eq, es;
    logic [63:0] eqw, edw;
    string ctag;
    model(fmt, w, pol, ns, st, en, eq, es, eqw, edw);
    @(negedge clk);
    in_fmt = fmt[1:0]; in_word = w; snan_pol = pol; no_snan = ns;
    dflt_style = st; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    #1;
    ctag = ns ? "R3" : (pol ? "R2" : "R1");
    chk("R8 valid after accept", {63'd0, out_valid}, 64'd1);
    chk((en == 0 && ((w >> 0) != 0) && !eq) ? "R4 is_nan" : {ctag, " is_nan"},
        {63'd0, out_is_nan}, {63'd0, en});
    chk({ctag, " is_quiet"}, {63'd0, out_is_quiet}, {63'd0, eq});
    chk({ctag, " is_sig"}, {63'd0, out_is_sig}, {63'd0, es});
    chk("R5 quieted word", out_quiet_word, eqw);
    chk((st == 2'd1 || st == 2'd2) ? "R7 default NaN" : "R6 default NaN", out_dflt_word, edw);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] lfsr;
    logic [63:0] garbage;
    lfsr = 64'hACE1_2468_9BDF_1357;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R8 reset quiet word", out_quiet_word, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // half: every all-ones-exponent word under every configuration, upper bits polluted
    for (int cfg = 0; cfg < 4; cfg++)
      for (int s = 0; s < 2; s++)
        for (int f = 0; f < 1024; f++) begin
          garbage = {48'hBEEF_0BAD_F00D, 16'h0};
          apply(0, garbage | {48'd0, s[0], 5'h1F, f[9:0]}, cfg[0], cfg[1], f[1:0]);
        end
    // half: finite exponents
    for (int ex = 0; ex < 31; ex++)
      for (int k = 0; k < 4; k++)
        apply(0, {48'd0, k[0], ex[4:0], (k[1] ? 10'h200 : 10'h001)}, k[0], 1'b0, 2'd0);
    // bfloat16: full all-ones-exponent sweep
    for (int cfg = 0; cfg < 4; cfg++)
      for (int v = 0; v < 256; v++)
        apply(1, {48'hFFFF_FFFF_FFFF, v[7], 8'hFF, v[6:0]}, cfg[0], cfg[1], v[2:1]);
    // single and double: corner fractions plus pseudo-random
    for (int cfg = 0; cfg < 4; cfg++) begin
      apply(2, 64'h0000_0000_7F80_0000, cfg[0], cfg[1], 2'd0); // R4 +inf
      apply(2, 64'h0000_0000_FF80_0000, cfg[0], cfg[1], 2'd1); // R4 -inf
      apply(2, 64'h0000_0000_7FC0_0000, cfg[0], cfg[1], 2'd2);
      apply(2, 64'h0000_0000_7F80_0001, cfg[0], cfg[1], 2'd3);
      apply(2, 64'h0000_0000_7FFF_FFFF, cfg[0], cfg[1], 2'd0);
      apply(2, 64'h0000_0000_7FA0_0000, cfg[0], cfg[1], 2'd1);
      apply(3, 64'h7FF0_0000_0000_0000, cfg[0], cfg[1], 2'd0); // R4 inf
      apply(3, 64'h7FF8_0000_0000_0000, cfg[0], cfg[1], 2'd1);
      apply(3, 64'hFFF0_0000_0000_0001, cfg[0], cfg[1], 2'd2);
      apply(3, 64'h7FF4_0000_0000_0000, cfg[0], cfg[1], 2'd3);
      apply(3, 64'h3FF0_0000_0000_0000, cfg[0], cfg[1], 2'd0);
      for (int r = 0; r < 200; r++) begin
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
        apply(2, lfsr | (r[0] ? 64'h7F80_0000 : 64'h0), cfg[0], cfg[1], lfsr[9:8]);
        apply(3, lfsr | (r[1] ? 64'h7FF0_0000_0000_0000 : 64'h0), cfg[0], cfg[1], lfsr[5:4]);
      end
    end

    // R9 back-pressure: drain, accept A with ready low, then B waits
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_fmt = 2'd2;
    in_word = 64'h7F80_0001; snan_pol = 1'b0; no_snan = 1'b0; dflt_style = 2'd0;
    @(posedge clk);
    #1;
    chk("R9 first word presented", out_quiet_word, 64'h7FC0_0001);
    @(negedge clk);
    in_word = 64'h7FC0_0000;
    #1;
    chk("R9 in_ready low while stalled", {63'd0, in_ready}, 64'd0);
    for (int h = 0; h < 3; h++) begin
      @(posedge clk);
      #1;
      chk("R9 held word stable", out_quiet_word, 64'h7FC0_0001);
      chk("R9 held valid", {63'd0, out_valid}, 64'd1);
    end
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk("R9 in_ready follows out_ready", {63'd0, in_ready}, 64'd1);
    @(posedge clk);
    #1;
    chk("R9 second word after release", out_quiet_word, 64'h7FC0_0000);
    @(negedge clk);
    in_valid = 1'b0;

    // R8 synchronous reset clears presented result
    @(negedge clk);
    in_valid = 1'b1; in_word = 64'h7F80_0001;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R8 reset clears valid", {63'd0, out_valid}, 64'd0);
    chk("R8 reset clears is_nan", {63'd0, out_is_nan}, 64'd0);
    chk("R8 reset clears quiet word", out_quiet_word, 64'd0);
    chk("R8 reset clears default word", out_dflt_word, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule